// File: doc/BRIEF.md
# Ripple-Carry Arithmetic-Logic Unit with Set-on-Less-Than

This block is a 32-bit arithmetic-logic unit built from a row of identical one-bit slices. Each slice holds an AND gate, an OR gate, a full adder and a four-way selector. The carry leaves each slice and enters the one above it, so the adder is a plain ripple chain. One subtract line inverts operand B inside every slice and also supplies the carry into bit 0. Together these give addition, two's-complement subtraction, and a signed "less than" test. That test takes the sign of A minus B from the top slice and feeds it back as the "less" input of bit 0. The "less" inputs of all other bits are tied low.

The result, a zero flag, a signed overflow flag and the carry out of the top slice are captured in an output register with a synchronous active-high reset. Every operation therefore shows at the ports one clock after its operands. A decoder upstream sets the two-bit operation select and the subtract line. Equality can be tested by subtracting and looking at the zero flag.

Top module: `ripple_alu`

## Requirements
- R1: With op_sel = 2'b00 and sub_en = 0, the result one clock later is the bitwise AND of opa and opb.
- R2: With op_sel = 2'b01 and sub_en = 0, the result one clock later is the bitwise OR of opa and opb.
- R3: With op_sel = 2'b10 and sub_en = 0, the result one clock later is (opa + opb) modulo 2^32, and cout_f is the carry out of bit 31.
- R4: With op_sel = 2'b10 and sub_en = 1, the result one clock later is (opa - opb) modulo 2^32, and cout_f is the carry out of opa + ~opb + 1. That carry is 1 exactly when opa >= opb as unsigned numbers.
- R5: With op_sel = 2'b11 and sub_en = 1, bits 31..1 of the result are 0. Bit 0 is bit 31 of (opa - opb) modulo 2^32. This is the signed "opa < opb" answer whenever the difference does not overflow, and its inverse whenever it does.
- R6: For every operation, zero_f is 1 exactly when all 32 bits of the registered result are 0.
- R7: For every operation, ovf_f is the XOR of the carry into bit 31 and the carry out of bit 31 of opa + (opb XOR {32{sub_en}}) + sub_en. It is therefore 1 for an add or subtract whose signed result does not fit in 32 bits.
- R8: While rst is high at a rising clock edge, res, zero_f, ovf_f and cout_f are all cleared to 0. From the first edge with rst low, they carry the outcome of the inputs present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| op_sel | input | 2 | Operation select: 00 AND, 01 OR, 10 adder, 11 less |
| sub_en | input | 1 | Inverts B and drives carry-in of bit 0 |
| res | output | 32 | Registered result |
| zero_f | output | 1 | Registered result-is-zero flag |
| ovf_f | output | 1 | Registered signed overflow flag |
| cout_f | output | 1 | Registered carry out of bit 31 |

## Verification
There is no internal state beyond the output register, so any slice fault shows at the ports one clock after the operands that expose it.

The bench picks operands that make each kind of fault visible:
- Carry chain: all-ones plus one, and its mirror in subtraction, send a carry through every slice. A broken link at any position then corrupts the upper bits and cout_f.
- Feedback path: operand pairs around the most negative and most positive values test the less-input wiring and the overflow rule. These include the two cases where the raw sign answer to "less than" is deliberately wrong.

Random operands mixed with these directed cases are checked against a model of R1 to R7 one cycle after each input change.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_SUM  = 2'b10,
    OP_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    cin_i,
  input  logic    less_i,
  input  logic    binv_i,
  input  alu_op_e op_i,
  output logic    res_o,
  output logic    sum_o,
  output logic    cout_o
);
  logic b_eff;

  assign b_eff  = b_i ^ binv_i;
  assign sum_o  = a_i ^ b_eff ^ cin_i;
  assign cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_eff;
      OP_OR:   res_o = a_i | b_eff;
      OP_SUM:  res_o = sum_o;
      OP_LESS: res_o = less_i;
      default: res_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  input  logic         sub_i,
  output logic [W-1:0] res_o,
  output logic         cin_msb_o,
  output logic         cout_o
);
  localparam int MSB = W - 1;

  logic [W:0]   carry;
  logic [W-1:0] sum;
  logic         set_bit;

  assign carry[0]  = sub_i;
  assign set_bit   = sum[MSB];
  assign cin_msb_o = carry[MSB];
  assign cout_o    = carry[W];

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_bit;
    end else begin : g_rest
      assign less_in = 1'b0;
    end
    alu_slice u_slice (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .cin_i  (carry[i]),
      .less_i (less_in),
      .binv_i (sub_i),
      .op_i   (op_i),
      .res_o  (res_o[i]),
      .sum_o  (sum[i]),
      .cout_o (carry[i+1])
    );
  end
endmodule

// File: rtl/alu_out_reg.sv
module alu_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] res_d,
  input  logic         zero_d,
  input  logic         ovf_d,
  input  logic         cout_d,
  output logic [W-1:0] res_q,
  output logic         zero_q,
  output logic         ovf_q,
  output logic         cout_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      zero_q <= 1'b0;
      ovf_q  <= 1'b0;
      cout_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      zero_q <= zero_d;
      ovf_q  <= ovf_d;
      cout_q <= cout_d;
    end
  end
endmodule

// File: rtl/ripple_alu.sv
module ripple_alu
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [1:0]   op_sel,
  input  logic         sub_en,
  output logic [W-1:0] res,
  output logic         zero_f,
  output logic         ovf_f,
  output logic         cout_f
);
  logic [W-1:0] res_c;
  logic         cin_msb;
  logic         cout_c;
  logic         zero_c;
  logic         ovf_c;

  alu_chain #(.W(W)) u_chain (
    .a_i       (opa),
    .b_i       (opb),
    .op_i      (alu_op_e'(op_sel)),
    .sub_i     (sub_en),
    .res_o     (res_c),
    .cin_msb_o (cin_msb),
    .cout_o    (cout_c)
  );

  assign zero_c = ~|res_c;
  assign ovf_c  = cin_msb ^ cout_c;

  alu_out_reg #(.W(W)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .res_d  (res_c),
    .zero_d (zero_c),
    .ovf_d  (ovf_c),
    .cout_d (cout_c),
    .res_q  (res),
    .zero_q (zero_f),
    .ovf_q  (ovf_f),
    .cout_q (cout_f)
  );
endmodule

// File: rtl/ripple_alu_chk.sv
module ripple_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [1:0]   op_sel,
  input logic         sub_en,
  input logic [W-1:0] res,
  input logic         zero_f,
  input logic         ovf_f,
  input logic         cout_f
);
  logic live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  AST_AND_RES: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00 && !sub_en) |=> res == ($past(opa) & $past(opb))); // R1
  AST_OR_RES: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01 && !sub_en) |=> res == ($past(opa) | $past(opb))); // R2
  AST_ADD_RES: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10 && !sub_en) |=> res == ($past(opa) + $past(opb))); // R3
  AST_SUB_RES: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10 && sub_en) |=> res == ($past(opa) - $past(opb))); // R4
  AST_LESS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b11 && sub_en) |=> res[W-1:1] == '0); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    live |-> zero_f == (res == '0)); // R6
  AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10 && !sub_en) |=>
      ovf_f == (($past(opa[W-1]) == $past(opb[W-1])) && (res[W-1] != $past(opa[W-1])))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (res == '0 && !zero_f && !ovf_f && !cout_f)); // R8
endmodule

bind ripple_alu ripple_alu_chk #(.W(W)) i_chk (
  .clk    (clk),
  .rst    (rst),
  .opa    (opa),
  .opb    (opb),
  .op_sel (op_sel),
  .sub_en (sub_en),
  .res    (res),
  .zero_f (zero_f),
  .ovf_f  (ovf_f),
  .cout_f (cout_f)
);

// File: tb/test_ripple_alu.sv
module test_ripple_alu;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [1:0]   op_sel = 2'b00;
  logic         sub_en = 1'b0;
  logic [W-1:0] res;
  logic         zero_f, ovf_f, cout_f;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  ripple_alu #(.W(W)) i_ripple_alu (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .op_sel(op_sel),
    .sub_en(sub_en), .res(res), .zero_f(zero_f), .ovf_f(ovf_f), .cout_f(cout_f)
  );

  typedef struct packed {
    logic [W-1:0] r;
    logic         z;
    logic         v;
    logic         c;
  } exp_t;

  function automatic exp_t model(logic [W-1:0] a, logic [W-1:0] b,
                                 logic [1:0] op, logic s);
    exp_t         e;
    logic [W-1:0] bx;
    logic [W:0]   full;
    logic [W-1:0] low;
    logic         cin_top;
    bx      = b ^ {W{s}};
    full    = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, s};
    low     = {1'b0, a[W-2:0]} + {1'b0, bx[W-2:0]} + {{(W-1){1'b0}}, s};
    cin_top = low[W-1];
    case (op)
      2'b00:   e.r = a & bx;
      2'b01:   e.r = a | bx;
      2'b10:   e.r = full[W-1:0];
      default: e.r = {{(W-1){1'b0}}, full[W-1]};
    endcase
    e.z = (e.r == '0);
    e.v = cin_top ^ full[W];
    e.c = full[W];
    return e;
  endfunction

  task automatic check(string tag, exp_t got, exp_t exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got r=%h z=%b v=%b c=%b expected r=%h z=%b v=%b c=%b",
               tag, got.r, got.z, got.v, got.c, exp.r, exp.z, exp.v, exp.c);
    end
  endtask

  task automatic run(string tag, logic [W-1:0] a, logic [W-1:0] b,
                     logic [1:0] op, logic s);
    @(negedge clk);
    opa = a; opb = b; op_sel = op; sub_en = s;
    @(negedge clk);
    check(tag, {res, zero_f, ovf_f, cout_f}, model(a, b, op, s));
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R8: cleared during reset
    check("R8 reset", {res, zero_f, ovf_f, cout_f}, '0);
    rst = 1'b0;
    // R1, R2 directed
    run("R1 and", 32'hF0F0_1234, 32'h0FF0_FFFF, 2'b00, 1'b0);
    run("R2 or",  32'h8000_0000, 32'h0000_0001, 2'b01, 1'b0);
    // R3 full ripple carry, R6 zero from add
    run("R3 ripple", 32'hFFFF_FFFF, 32'h0000_0001, 2'b10, 1'b0);
    // R7 positive overflow
    run("R7 pos ovf", 32'h7FFF_FFFF, 32'h0000_0001, 2'b10, 1'b0);
    run("R7 neg ovf", 32'h8000_0000, 32'h8000_0000, 2'b10, 1'b0);
    // R4 subtraction borrow and equality (R6)
    run("R4 borrow", 32'h0000_0000, 32'h0000_0001, 2'b10, 1'b1);
    run("R6 equal",  32'h1234_5678, 32'h1234_5678, 2'b10, 1'b1);
    run("R7 sub ovf", 32'h8000_0000, 32'h0000_0001, 2'b10, 1'b1);
    // R5 less: true, false, and the two overflow cases with inverted answer
    run("R5 lt true",  32'hFFFF_FFF9, 32'h0000_0005, 2'b11, 1'b1);
    run("R5 lt false", 32'h0000_0005, 32'hFFFF_FFF9, 2'b11, 1'b1);
    run("R5 ovf low",  32'h8000_0000, 32'h0000_0001, 2'b11, 1'b1);
    run("R5 ovf high", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b11, 1'b1);
    // random mix over all operations
    for (int i = 0; i < 600; i++) begin
      logic [1:0]   op;
      logic [W-1:0] a, b;
      logic         s;
      op = 2'($urandom());
      a  = $urandom();
      b  = (i % 7 == 0) ? a : $urandom();
      s  = (op == 2'b11) ? 1'b1 : (op == 2'b10) ? 1'($urandom()) : 1'b0;
      case (op)
        2'b00:   run("R1 random", a, b, op, s);
        2'b01:   run("R2 random", a, b, op, s);
        2'b10:   run(s ? "R4 random" : "R3 random", a, b, op, s);
        default: run("R5 random", a, b, op, s);
      endcase
    end
    // R8 reset again mid-run
    @(negedge clk);
    opa = 32'hFFFF_FFFF; opb = 32'h1; op_sel = 2'b10; sub_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R8 reset mid", {res, zero_f, ovf_f, cout_f}, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule